// File: doc/BRIEF.md
# Small Register Machine Core

A multi-cycle 8-bit processor core. It holds a program counter, four general byte registers (R0 to R3), a stack pointer that grows toward lower addresses and a three-bit condition register. It fetches byte-wide instructions through one synchronous memory port, sorts each opcode into a two-operand, one-operand or zero-operand group, and runs it over one to three cycles: fetch, decode and an optional operand cycle.

Two-operand instructions move, combine or compare a source with a destination register. The source is a register or a constant taken from the byte after the opcode. One-operand instructions cover conditional and unconditional jumps, a subroutine call, bitwise complement, push and pop. Zero-operand instructions are halt, no-operation and return. The core reports through two status outputs. `stopped` means it has ceased fetching. `error` means it stopped because of a bad encoding or a return with an empty stack. Only a reset restarts it.

Top module: `smc_core`

## Requirements
- R1: While reset is low, and at the first cycle after it rises, `stopped` and `error` are 0, the core reads address 0, all four registers and the condition flags hold 0, and the stack pointer holds the last memory address.
- R2: The groups are tested in this order. Two-operand: opcode bits [7:6] are not 00. One-operand: bits [7:5] are 001. Zero-operand: bits [7:4] are 0001. Bits [7:4] = 0000 match no group. A code that matches no group, or a code that is undefined inside its group, sets `stopped` and `error` together, and both then stay set until reset.
- R3: In the two-operand format, bits [7:5] give the operation: 2 move, 3 OR, 4 AND, 5 subtract, 6 compare, 7 add. Bits [4:2] give the source: 0 to 3 name a register, 4 takes the next memory byte as a constant, and 5 to 7 are illegal. Bits [1:0] name the destination register. Move, OR, AND, add and subtract write the destination modulo 256 and change no flag. Subtract computes destination minus source.
- R4: Compare writes no register. It sets Z (condition bit 0) when source equals destination and clears it otherwise. C (bit 1) and V (bit 2) are left as they are.
- R5: Opcode 0x30+r replaces register r with its bitwise complement. Codes 0x34 to 0x37 are illegal.
- R6: Push (0x28+s, with s a source code 0 to 4) stores the operand at the stack pointer and then decrements it. Codes 0x2D to 0x2F are illegal. Pop (0x20+r) first increments the stack pointer and then loads register r from that address. Codes 0x24 to 0x27 are illegal.
- R7: A jump (0x38+c) reads its target from the next byte. Conditions by c: 0 always, 1 Z=1, 2 Z=0, 3 C=1, 4 C=1 or Z=1, 5 C=0 and Z=0, 6 C=0, 7 call (always taken). A jump that is not taken resumes at the byte after the target.
- R8: A call pushes the address of the byte after its target (store, then decrement) and then jumps. Return (0x12) increments the stack pointer and loads the program counter from that address. A return issued while the stack pointer holds the last address sets `stopped` and `error`.
- R9: Halt (0x10) sets `stopped` without `error`. No-operation (0x11) only advances. Once `stopped` is set, the core makes no memory read or write until reset.
- R10: Read data is returned the cycle after `mem_rd`. `mem_rd` and `mem_wr` are never both high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | AW | Memory address for a read or a write |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data of the previous cycle's read |
| stopped | output | 1 | Core has ceased execution |
| error | output | 1 | Core stopped on an illegal code or a stack underflow |

## Verification
Registers and flags have no port of their own, so the hard part is seeing their values at all. Each test program ends by pushing registers onto the stack and encoding the Z flag as the choice of a jump path. The bench then reads the stack area of its memory model. Conditions that depend on C are hard to reach because no instruction ever sets C. Those jumps are tested with C fixed at zero against both values of Z, with Z set or cleared by an earlier compare of equal or unequal registers.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int DW = 8;
    localparam int NREG = 4;

    localparam logic [2:0] SRC_IMM = 3'd4;

    localparam int Z_BIT = 0;
    localparam int C_BIT = 1;
    localparam int V_BIT = 2;

    typedef enum logic [1:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC,
        S_HALT
    } state_e;

    typedef enum logic [3:0] {
        K_ALU,
        K_JMP,
        K_NOT,
        K_PUSH,
        K_POP,
        K_HLT,
        K_NOP,
        K_RET,
        K_ILL
    } kind_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_RSV  = 3'd1,
        OP_MOV  = 3'd2,
        OP_OR   = 3'd3,
        OP_AND  = 3'd4,
        OP_SUB  = 3'd5,
        OP_CMP  = 3'd6,
        OP_ADD  = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        J_ALW,
        J_EQ,
        J_NE,
        J_LO,
        J_LS,
        J_HI,
        J_HS,
        J_CALL
    } cond_e;

    typedef struct packed {
        kind_e      kind;
        alu_op_e    op;
        logic [2:0] src;
        logic [1:0] dst;
        cond_e      cond;
        logic       imm;
    } dec_t;

endpackage

// File: rtl/smc_decode.sv
module smc_decode
    import smc_pkg::*;
(
    input  logic [DW-1:0] ir,
    output dec_t          dec
);

    always_comb begin
        dec.kind = K_ILL;
        dec.op   = OP_NONE;
        dec.src  = ir[4:2];
        dec.dst  = ir[1:0];
        dec.cond = cond_e'(ir[2:0]);
        dec.imm  = 1'b0;

        if (ir[7:6] != 2'b00) begin
            // two-operand group
            dec.op  = alu_op_e'(ir[7:5]);
            dec.src = ir[4:2];
            dec.dst = ir[1:0];
            dec.imm = (ir[4:2] == SRC_IMM);
            dec.kind = (ir[4:2] <= SRC_IMM) ? K_ALU : K_ILL;
        end else if (ir[7:5] == 3'b001) begin
            // one-operand group
            dec.src = ir[2:0];
            dec.dst = ir[1:0];
            unique case (ir[4:3])
                2'b11: dec.kind = K_JMP;
                2'b10: dec.kind = ir[2] ? K_ILL : K_NOT;
                2'b01: begin
                    dec.kind = (ir[2:0] <= SRC_IMM) ? K_PUSH : K_ILL;
                    dec.imm  = (ir[2:0] == SRC_IMM);
                end
                default: dec.kind = ir[2] ? K_ILL : K_POP;
            endcase
        end else if (ir[7:4] == 4'b0001) begin
            // zero-operand group
            unique case (ir[3:0])
                4'h0:    dec.kind = K_HLT;
                4'h1:    dec.kind = K_NOP;
                4'h2:    dec.kind = K_RET;
                default: dec.kind = K_ILL;
            endcase
        end
    end

endmodule

// File: rtl/smc_alu.sv
module smc_alu
    import smc_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a_dst,
    input  logic [DW-1:0] b_src,
    output logic [DW-1:0] res,
    output logic          same
);

    always_comb begin
        same = (a_dst == b_src);
        unique case (op)
            OP_MOV:  res = b_src;
            OP_OR:   res = a_dst | b_src;
            OP_AND:  res = a_dst & b_src;
            OP_SUB:  res = a_dst - b_src;
            OP_ADD:  res = a_dst + b_src;
            default: res = a_dst;
        endcase
    end

endmodule

// File: rtl/smc_branch.sv
module smc_branch
    import smc_pkg::*;
(
    input  cond_e      cond,
    input  logic [2:0] ccr,
    output logic       take
);

    logic z;
    logic c;

    always_comb begin
        z = ccr[Z_BIT];
        c = ccr[C_BIT];
        unique case (cond)
            J_ALW:   take = 1'b1;
            J_EQ:    take = z;
            J_NE:    take = !z;
            J_LO:    take = c;
            J_LS:    take = c || z;
            J_HI:    take = !c && !z;
            J_HS:    take = !c;
            default: take = 1'b1;
        endcase
    end

endmodule

// File: rtl/smc_core.sv
module smc_core
    import smc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          stopped,
    output logic          error
);

    localparam logic [AW-1:0] SP_TOP = {AW{1'b1}};
    localparam logic [AW-1:0] ONE    = AW'(1);

    typedef struct packed {
        state_e                  st;
        logic [AW-1:0]           pc;
        logic [AW-1:0]           sp;
        logic [NREG-1:0][DW-1:0] gpr;
        logic [2:0]              ccr;
        logic [DW-1:0]           ir;
        logic                    stopped;
        logic                    error;
    } core_t;

    core_t q, d;

    logic [DW-1:0] ir_now;
    dec_t          dec;
    logic [DW-1:0] src_val;
    logic [DW-1:0] dst_val;
    logic [DW-1:0] alu_res;
    logic          alu_same;
    logic          jmp_take;

    assign ir_now  = (q.st == S_DECODE) ? mem_rdata : q.ir;
    assign src_val = (q.st == S_EXEC) ? mem_rdata : q.gpr[dec.src[1:0]];
    assign dst_val = q.gpr[dec.dst];

    smc_decode u_dec (
        .ir  (ir_now),
        .dec (dec)
    );

    smc_alu u_alu (
        .op    (dec.op),
        .a_dst (dst_val),
        .b_src (src_val),
        .res   (alu_res),
        .same  (alu_same)
    );

    smc_branch u_br (
        .cond (dec.cond),
        .ccr  (q.ccr),
        .take (jmp_take)
    );

    always_comb begin
        d         = q;
        mem_addr  = q.pc;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;

        unique case (q.st)
            S_FETCH: begin
                mem_rd = 1'b1;
                mem_addr = q.pc;
                d.st = S_DECODE;
            end

            S_DECODE: begin
                d.ir = mem_rdata;
                d.st = S_FETCH;
                unique case (dec.kind)
                    K_ALU: begin
                        if (dec.imm) begin
                            mem_rd   = 1'b1;
                            mem_addr = q.pc + ONE;
                            d.pc     = q.pc + ONE;
                            d.st     = S_EXEC;
                        end else begin
                            if (dec.op == OP_CMP) begin
                                d.ccr[Z_BIT] = alu_same;
                            end else begin
                                d.gpr[dec.dst] = alu_res;
                            end
                            d.pc = q.pc + ONE;
                        end
                    end
                    K_JMP: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.pc + ONE;
                        d.pc     = q.pc + ONE;
                        d.st     = S_EXEC;
                    end
                    K_NOT: begin
                        d.gpr[dec.dst] = ~dst_val;
                        d.pc = q.pc + ONE;
                    end
                    K_PUSH: begin
                        if (dec.imm) begin
                            mem_rd   = 1'b1;
                            mem_addr = q.pc + ONE;
                            d.pc     = q.pc + ONE;
                            d.st     = S_EXEC;
                        end else begin
                            mem_wr    = 1'b1;
                            mem_addr  = q.sp;
                            mem_wdata = src_val;
                            d.sp      = q.sp - ONE;
                            d.pc      = q.pc + ONE;
                        end
                    end
                    K_POP: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.sp + ONE;
                        d.sp     = q.sp + ONE;
                        d.st     = S_EXEC;
                    end
                    K_RET: begin
                        if (q.sp == SP_TOP) begin
                            d.stopped = 1'b1;
                            d.error   = 1'b1;
                            d.st      = S_HALT;
                        end else begin
                            mem_rd   = 1'b1;
                            mem_addr = q.sp + ONE;
                            d.sp     = q.sp + ONE;
                            d.st     = S_EXEC;
                        end
                    end
                    K_HLT: begin
                        d.stopped = 1'b1;
                        d.pc      = q.pc + ONE;
                        d.st      = S_HALT;
                    end
                    K_NOP: begin
                        d.pc = q.pc + ONE;
                    end
                    default: begin
                        d.stopped = 1'b1;
                        d.error   = 1'b1;
                        d.st      = S_HALT;
                    end
                endcase
            end

            S_EXEC: begin
                d.st = S_FETCH;
                unique case (dec.kind)
                    K_ALU: begin
                        if (dec.op == OP_CMP) begin
                            d.ccr[Z_BIT] = alu_same;
                        end else begin
                            d.gpr[dec.dst] = alu_res;
                        end
                        d.pc = q.pc + ONE;
                    end
                    K_JMP: begin
                        if (jmp_take) begin
                            d.pc = AW'(mem_rdata);
                            if (dec.cond == J_CALL) begin
                                mem_wr    = 1'b1;
                                mem_addr  = q.sp;
                                mem_wdata = DW'(q.pc + ONE);
                                d.sp      = q.sp - ONE;
                            end
                        end else begin
                            d.pc = q.pc + ONE;
                        end
                    end
                    K_PUSH: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = mem_rdata;
                        d.sp      = q.sp - ONE;
                        d.pc      = q.pc + ONE;
                    end
                    K_POP: begin
                        d.gpr[dec.dst] = mem_rdata;
                        d.pc = q.pc + ONE;
                    end
                    K_RET: begin
                        d.pc = AW'(mem_rdata);
                    end
                    default: begin
                        d.stopped = 1'b1;
                        d.error   = 1'b1;
                        d.st      = S_HALT;
                    end
                endcase
            end

            default: begin
                d.st = S_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= S_FETCH;
            q.pc      <= '0;
            q.sp      <= SP_TOP;
            q.gpr     <= '0;
            q.ccr     <= '0;
            q.ir      <= '0;
            q.stopped <= 1'b0;
            q.error   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign stopped = q.stopped;
    assign error   = q.error;

endmodule

// File: rtl/smc_core_chk.sv
module smc_core_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_rd,
    input logic mem_wr,
    input logic stopped,
    input logic error
);

    // R10
    rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (!mem_rd && !mem_wr));

    // R9
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> stopped);

    // R2
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> stopped);

    // R2
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

endmodule

bind smc_core smc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .stopped (stopped),
    .error   (error)
);

// File: tb/smc_core_bench.sv
`timescale 1ns/1ps
module smc_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr;
    logic       mem_rd;
    logic       mem_wr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic       stopped;
    logic       error;

    logic       ld_clr = 1'b0;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] mem [256];
    logic [7:0] prog [$];

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    smc_core #(.AW(8)) u_smc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .stopped   (stopped),
        .error     (error)
    );

    always @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'hEE;
        end else if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input int op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            0: return b;
            1: return a | b;
            2: return a & b;
            3: return a - b;
            5: return a + b;
            default: return a;
        endcase
    endfunction

    task automatic run_prog();
        rst_n = 1'b0;
        @(negedge clk) ld_clr = 1'b1;
        @(negedge clk) ld_clr = 1'b0;
        for (int i = 0; i < prog.size(); i++) begin
            ld_we = 1'b1; ld_addr = 8'(i); ld_data = prog[i];
            @(negedge clk);
        end
        ld_we = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        for (int k = 0; k < 400 && !stopped; k++) @(negedge clk);
        chk("R9 run ends", stopped, 1'b1);
    endtask

    task automatic emit(input logic [7:0] b);
        prog.push_back(b);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] a, b, exp_r;
        int op, idx, cnt;
        bit uc, z, taken;
        void'($urandom(32'd4242));

        // R1 reset state and first fetch address
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 stopped in reset", stopped, 1'b0);
        chk("R1 error in reset", error, 1'b0);
        @(negedge clk) ld_clr = 1'b1;
        @(negedge clk) ld_clr = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 first read strobe", mem_rd, 1'b1);
        chk("R1 first read address", mem_addr, 8'h00);

        // R1 registers zero, SP at top
        prog = {8'h28, 8'h29, 8'h2A, 8'h2B, 8'h10};
        run_prog();
        chk("R9 halt no error", error, 1'b0);
        for (int r = 0; r < 4; r++) chk("R1 reg cleared", mem[255 - r], 8'h00);
        chk("R6 sp after four pushes", mem[251], 8'hEE);

        // R9 no access once stopped
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (mem_rd || mem_wr) cnt++;
        end
        chk("R9 quiet after halt", 8'(cnt), 8'h00);

        // R2 illegal codes at each level
        prog = {8'h11, 8'h05};          // no group
        run_prog();
        chk("R2 no group error", error, 1'b1);
        prog = {8'h54};                 // two-operand source code 5
        run_prog();
        chk("R2 bad source error", error, 1'b1);
        prog = {8'h34};                 // complement of constant
        run_prog();
        chk("R5 0x34 illegal", error, 1'b1);
        prog = {8'h2D};                 // push code 5
        run_prog();
        chk("R6 push 0x2D illegal", error, 1'b1);
        prog = {8'h13};                 // zero-operand undefined
        run_prog();
        chk("R2 zero group error", error, 1'b1);
        prog = {8'h11, 8'h11, 8'h10};   // R9 nop then halt
        run_prog();
        chk("R9 nop halt error", error, 1'b0);

        // R5 R6 pop then complement
        prog = {8'h2C, 8'h5A, 8'h23, 8'h33, 8'h2B, 8'h2C, 8'h01, 8'h2C, 8'h02, 8'h10};
        run_prog();
        chk("R5 complement of popped", mem[255], 8'hA5);
        chk("R6 push order first", mem[254], 8'h01);
        chk("R6 push order second", mem[253], 8'h02);

        // R8 call and return
        prog = {8'h50, 8'h07, 8'h3F, 8'h06, 8'h28, 8'h10, 8'hF0, 8'h01, 8'h12};
        run_prog();
        chk("R8 call/return flow", mem[255], 8'h08);
        chk("R8 return no error", error, 1'b0);
        prog = {8'h12};
        run_prog();
        chk("R8 return underflow", error, 1'b1);

        // R7 every condition against Z=0 and Z=1 (C stays 0)
        for (int c = 0; c < 8; c++) begin
            for (int zz = 0; zz < 2; zz++) begin
                prog.delete();
                if (zz == 1) emit(8'hC0);
                else begin emit(8'h51); emit(8'h01); emit(8'hC4); end
                idx = prog.size();
                emit(8'h38 | 8'(c)); emit(8'(idx + 5));
                emit(8'h2C); emit(8'hAA); emit(8'h10);
                emit(8'h2C); emit(8'hBB); emit(8'h10);
                run_prog();
                case (c)
                    1: taken = (zz == 1);
                    2: taken = (zz == 0);
                    3: taken = 1'b0;
                    4: taken = (zz == 1);
                    5: taken = (zz == 0);
                    default: taken = 1'b1;
                endcase
                if (c == 7) begin
                    chk("R8 call return address", mem[255], 8'(idx + 2));
                    chk("R7 call taken", mem[254], 8'hBB);
                end else begin
                    chk("R7 jump outcome", mem[255], taken ? 8'hBB : 8'hAA);
                end
            end
        end

        // R3 R4 random operations with register or constant source
        for (int t = 0; t < 48; t++) begin
            a  = 8'($urandom);
            b  = ($urandom % 4 == 0) ? a : 8'($urandom);
            op = int'($urandom % 6);
            uc = 1'($urandom);
            prog.delete();
            emit(8'h50); emit(a); emit(8'h51); emit(b);
            if (uc) begin emit(8'(((op + 2) << 5) | 8'h10)); emit(b); end
            else emit(8'(((op + 2) << 5) | 8'h04));
            emit(8'h28);
            idx = prog.size();
            emit(8'h39); emit(8'h00);
            emit(8'h2C); emit(8'h00); emit(8'h10);
            prog[idx + 1] = 8'(prog.size());
            emit(8'h2C); emit(8'h01); emit(8'h10);
            run_prog();
            exp_r = model(op, a, b);
            z = (op == 4) && (a == b);
            chk(op == 4 ? "R4 compare keeps dest" : "R3 alu result", mem[255], exp_r);
            chk(op == 4 ? "R4 Z from compare" : "R3 flags unchanged", mem[254], {7'b0, z});
            chk("R3 no error", error, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule